// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave Controller

This block is the control logic of a small serial memory that a host reaches over a three-wire link. The link has a select line, a serial clock and a data-in line, plus a data-out line that can float. All five slave inputs come from outside the system clock domain. They pass through synchronisers, and every edge of the serial clock is detected in the system clock domain. While select is high the controller waits for a start bit. It then shifts in a 2-bit opcode, an 8-bit address and, for a write, a 16-bit word. It then reads, writes or erases a word of a register-based array. It also runs the enable, disable and protection commands.

A write or erase that is accepted starts a self-timed program cycle. The cycle lasts a set number of system clocks, and no new instruction is taken until it ends. A host polls for completion by dropping select and raising it again. Data-out then reports busy (0) until the cycle ends and ready (1) afterwards. A protection boundary register write-protects every address at or above its value. Two pins gate some commands: a program-enable pin, and a protect-select pin that switches the opcodes over to the protection commands. A one-shot lock command freezes the boundary for good.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, and whenever no read is shifting out and no status is shown, `sdo_oe_o` is 0.
- R2: With select high and no start bit seen, serial clocks with data-in 0 change nothing. The first 1 sampled is the start bit.
- R3: The frame is start bit, opcode (10 read, 01 write, 11 erase, 00 extended), 8 address bits MSB first, then for a write 16 data bits MSB first. Bits are sampled on the serial clock's rising edge. A completed write stores its word.
- R4: A read drives a 0 first, then the 16 stored bits MSB first, each after a rising serial edge. On the next rising edge the output is released.
- R5: Select going low before a frame completes discards it with no effect. The next frame starts afresh.
- R6: Writes start disabled. Extended code with address bits [7:6]=11 enables them and [7:6]=00 disables them. A write or erase while disabled is ignored and starts no program cycle.
- R7: An accepted erase sets the word to 16'hFFFF. The array resets to all ones.
- R8: An accepted write, erase or protection command starts a program cycle of PROG_CYCLES system clocks. Start bits during the cycle are ignored.
- R9: If select rises during a program cycle, data-out shows 0 while busy and then 1 while select stays high. If select stays high through the whole cycle, data-out is not driven.
- R10: The boundary register resets to 256, which protects nothing. A write or erase at an address at or above it is ignored and starts no cycle.
- R11: With protect-select high, opcode 10 reads the boundary zero-extended to 16 bits. Opcode 01 sets the boundary to the address, opcode 11 sets it to 256, and extended [7:6]=11 arms these commands. A setting command takes effect only when the instruction just before it was an arming command issued with program-enable high.
- R12: With protect-select high, extended address 8'h00 locks the boundary for good. This needs program-enable high and an arming command immediately before it. After a lock, boundary changes are ignored.
- R13: With program-enable low, writes, erases and boundary changes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Select, high selects the slave |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| pe_i | input | 1 | Program enable |
| pre_i | input | 1 | Protect select, high chooses the protection commands |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for serial data out |

## Verification
Most internal faults show up as data: a wrong stored word, a missing dummy bit or a shifted read. A read of the affected address reports the fault within one frame. A wrong write-enable flag, arming flag or boundary value shows up when a later program command either raises a busy status it should not or fails to raise one. The bench toggles select right after each such command, so the fault appears within about a dozen system clocks. A stuck cycle counter appears as a busy status that never turns to ready, or as a following frame that gets ignored.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int OP_W   = 2;
    localparam int HDR_W  = OP_W + ADDR_W;
    localparam int PROT_W = ADDR_W + 1;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BIT_CNT_W = $clog2((HDR_W > DATA_W ? HDR_W : DATA_W) + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PROT_W-1:0] prot_t;

    localparam prot_t PROT_NONE = prot_t'(DEPTH);

    typedef struct packed {
        logic sel;
        logic sclk;
        logic din;
        logic pgm;
        logic psel;
    } pins_t;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        K_NOP, K_READ, K_WRITE, K_ERASE, K_WEN, K_WDIS,
        K_PREAD, K_PWRITE, K_PCLEAR, K_PARM, K_PLOCK
    } kind_e;

    typedef struct packed {
        kind_e kind;
        addr_t addr;
        word_t data;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_DATA, S_READ, S_DONE
    } fe_state_e;

    function automatic kind_e decode_cmd(input op_e op, input addr_t a, input logic psel);
        case (op)
            OP_READ:  return psel ? K_PREAD  : K_READ;
            OP_WRITE: return psel ? K_PWRITE : K_WRITE;
            OP_ERASE: return psel ? K_PCLEAR : K_ERASE;
            default: begin
                if (a[ADDR_W-1 -: 2] == 2'b11) return psel ? K_PARM  : K_WEN;
                if (a[ADDR_W-1 -: 2] == 2'b00) return psel ? K_PLOCK : K_WDIS;
                return K_NOP;
            end
        endcase
    endfunction
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mw_frontend.sv
module mw_frontend import mw_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  sel,
    input  logic  sck_rise,
    input  logic  din,
    input  logic  psel,
    input  logic  busy,
    input  word_t mem_word,
    input  prot_t prot_val,
    output addr_t look_addr,
    output logic  exec,
    output cmd_t  cmd,
    output logic  start,
    output logic  out_en,
    output logic  out_bit,
    output logic  idle
);
    fe_state_e              state;
    logic [BIT_CNT_W-1:0]   cnt;
    logic [HDR_W-1:0]       hdr;
    logic [HDR_W-1:0]       hdr_next;
    word_t                  dat;
    word_t                  dat_next;
    word_t                  rd_sr;
    kind_e                  kind;
    logic                   hdr_last;
    logic                   dat_last;

    assign hdr_next  = {hdr[HDR_W-2:0], din};
    assign dat_next  = {dat[DATA_W-2:0], din};
    assign look_addr = hdr_next[ADDR_W-1:0];
    assign kind      = decode_cmd(op_e'(hdr_next[HDR_W-1 -: OP_W]), look_addr, psel);
    assign hdr_last  = (state == S_HDR)  && (cnt == BIT_CNT_W'(HDR_W-1));
    assign dat_last  = (state == S_DATA) && (cnt == BIT_CNT_W'(DATA_W-1));
    assign idle      = (state == S_IDLE);

    // control path: held in reset while select is low
    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            state   <= S_IDLE;
            cnt     <= '0;
            exec    <= 1'b0;
            start   <= 1'b0;
            out_en  <= 1'b0;
            out_bit <= 1'b0;
        end else begin
            exec  <= 1'b0;
            start <= 1'b0;
            if (sck_rise) begin
                case (state)
                    S_IDLE: if (din && !busy) begin
                        state <= S_HDR;
                        cnt   <= '0;
                        start <= 1'b1;
                    end
                    S_HDR: begin
                        cnt <= cnt + 1'b1;
                        if (hdr_last) begin
                            cnt <= '0;
                            case (kind)
                                K_READ, K_PREAD: begin
                                    state   <= S_READ;
                                    out_en  <= 1'b1;
                                    out_bit <= 1'b0;
                                    exec    <= 1'b1;
                                end
                                K_WRITE: state <= S_DATA;
                                default: begin
                                    state <= S_DONE;
                                    exec  <= 1'b1;
                                end
                            endcase
                        end
                    end
                    S_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (dat_last) begin
                            state <= S_DONE;
                            exec  <= 1'b1;
                        end
                    end
                    S_READ: begin
                        if (cnt == BIT_CNT_W'(DATA_W)) begin
                            out_en <= 1'b0;
                            state  <= S_DONE;
                        end else begin
                            out_bit <= rd_sr[DATA_W-1];
                            cnt     <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hdr   <= '0;
            dat   <= '0;
            rd_sr <= '0;
            cmd   <= '{kind: K_NOP, addr: '0, data: '0};
        end else if (sck_rise && sel) begin
            if (state == S_HDR) begin
                hdr <= hdr_next;
                if (hdr_last) begin
                    cmd.kind <= kind;
                    cmd.addr <= look_addr;
                    cmd.data <= '1;
                    rd_sr    <= (kind == K_PREAD) ? word_t'(prot_val) : mem_word;
                end
            end
            if (state == S_DATA) begin
                dat <= dat_next;
                if (dat_last) cmd.data <= dat_next;
            end
            if (state == S_READ && cnt != BIT_CNT_W'(DATA_W))
                rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mw_core.sv
module mw_core import mw_pkg::*; #(
    parameter int PROG_CYCLES = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  exec,
    input  cmd_t  cmd,
    input  logic  pgm,
    input  logic  sel,
    input  logic  sel_rise,
    input  logic  start,
    input  addr_t look_addr,
    output word_t mem_word,
    output prot_t prot_val,
    output logic  busy,
    output logic  lock,
    output logic  prog_go,
    output logic  status_en
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    word_t              mem [DEPTH];
    logic               wen;
    logic               armed;
    logic               show;
    logic [CNT_W-1:0]   cnt;
    logic               in_range;
    logic               prot_ok;
    logic               go;
    logic               is_data;

    always_comb begin
        in_range = {1'b0, cmd.addr} < prot_val;
        prot_ok  = pgm && armed && !lock;
        is_data  = (cmd.kind == K_WRITE) || (cmd.kind == K_ERASE);
        case (cmd.kind)
            K_WRITE, K_ERASE:   go = wen && pgm && in_range;
            K_PWRITE, K_PCLEAR: go = prot_ok;
            K_PLOCK:            go = prot_ok && (cmd.addr == '0);
            default:            go = 1'b0;
        endcase
    end

    assign busy      = (cnt != '0);
    assign prog_go   = exec && go && !busy;
    assign status_en = show && sel;
    assign mem_word  = mem[look_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (prog_go && is_data) begin
            mem[cmd.addr] <= cmd.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wen      <= 1'b0;
            armed    <= 1'b0;
            lock     <= 1'b0;
            prot_val <= PROT_NONE;
            cnt      <= '0;
            show     <= 1'b0;
        end else begin
            if (exec) begin
                armed <= (cmd.kind == K_PARM) && pgm;
                if (cmd.kind == K_WEN)  wen <= 1'b1;
                if (cmd.kind == K_WDIS) wen <= 1'b0;
            end
            if (prog_go) begin
                case (cmd.kind)
                    K_PWRITE: prot_val <= {1'b0, cmd.addr};
                    K_PCLEAR: prot_val <= PROT_NONE;
                    K_PLOCK:  lock     <= 1'b1;
                    default:  ;
                endcase
                cnt <= CNT_W'(PROG_CYCLES);
            end else if (busy) begin
                cnt <= cnt - 1'b1;
            end
            if (busy && sel_rise)              show <= 1'b1;
            else if (!busy && (!sel || start)) show <= 1'b0;
        end
    end
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave import mw_pkg::*; #(
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic sck_i,
    input  logic sdi_i,
    input  logic pe_i,
    input  logic pre_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    pins_t  pins_raw;
    pins_t  pins_s;
    logic   sck_d;
    logic   cs_d;
    logic   cs_s;
    logic   sck_rise;
    logic   cs_rise;
    addr_t  look_addr;
    word_t  mem_word;
    prot_t  prot_val;
    cmd_t   cmd;
    logic   exec;
    logic   fe_start;
    logic   fe_out_en;
    logic   fe_out_bit;
    logic   fe_idle;
    logic   busy;
    logic   lock;
    logic   prog_go;
    logic   status_en;

    assign pins_raw = '{sel: cs_i, sclk: sck_i, din: sdi_i, pgm: pe_i, psel: pre_i};

    mw_sync #(.WIDTH($bits(pins_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b0;
        end else begin
            sck_d <= pins_s.sclk;
            cs_d  <= pins_s.sel;
        end
    end

    assign cs_s     = pins_s.sel;
    assign sck_rise = pins_s.sclk && !sck_d;
    assign cs_rise  = pins_s.sel && !cs_d;

    mw_frontend u_fe (
        .clk       (clk),
        .rst       (rst),
        .sel       (cs_s),
        .sck_rise  (sck_rise),
        .din       (pins_s.din),
        .psel      (pins_s.psel),
        .busy      (busy),
        .mem_word  (mem_word),
        .prot_val  (prot_val),
        .look_addr (look_addr),
        .exec      (exec),
        .cmd       (cmd),
        .start     (fe_start),
        .out_en    (fe_out_en),
        .out_bit   (fe_out_bit),
        .idle      (fe_idle)
    );

    mw_core #(.PROG_CYCLES(PROG_CYCLES)) u_core (
        .clk       (clk),
        .rst       (rst),
        .exec      (exec),
        .cmd       (cmd),
        .pgm       (pins_s.pgm),
        .sel       (cs_s),
        .sel_rise  (cs_rise),
        .start     (fe_start),
        .look_addr (look_addr),
        .mem_word  (mem_word),
        .prot_val  (prot_val),
        .busy      (busy),
        .lock      (lock),
        .prog_go   (prog_go),
        .status_en (status_en)
    );

    assign sdo_oe_o = fe_out_en || status_en;
    assign sdo_o    = fe_out_en ? fe_out_bit : (status_en && !busy);
endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker import mw_pkg::*; (
    input logic  clk,
    input logic  rst,
    input logic  sdo_o,
    input logic  sdo_oe_o,
    input logic  fe_idle,
    input logic  status_en,
    input logic  fe_out_en,
    input logic  busy,
    input logic  fe_start,
    input logic  lock,
    input logic  prog_go,
    input logic  cs_s,
    input cmd_t  cmd,
    input prot_t prot_val
);
    assert_hiz_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (fe_idle && !status_en) |-> !sdo_oe_o);

    assert_dummy_first_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(fe_out_en) |-> !sdo_o);

    assert_deselect_abort_R5: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> !fe_out_en);

    assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !fe_start);

    assert_boundary_R10: assert property (@(posedge clk) disable iff (rst)
        (prog_go && (cmd.kind == K_WRITE || cmd.kind == K_ERASE)) |-> ({1'b0, cmd.addr} < prot_val));

    assert_lock_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);
endmodule

bind mw_eeprom_slave mw_eeprom_checker u_check (
    .clk       (clk),
    .rst       (rst),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o),
    .fe_idle   (fe_idle),
    .status_en (status_en),
    .fe_out_en (fe_out_en),
    .busy      (busy),
    .fe_start  (fe_start),
    .lock      (lock),
    .prog_go   (prog_go),
    .cs_s      (cs_s),
    .cmd       (cmd),
    .prot_val  (prot_val)
);

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_WAIT  = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, pe = 1'b1, pre = 1'b0;
    logic sdo, sdo_oe;
    int checks = 0;
    int errors = 0;
    logic [15:0] model [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_slave uut (
        .clk(clk), .rst(rst), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
        .pe_i(pe), .pre_i(pre), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        sck = 1'b0; sdi = b; tick(4);
        sck = 1'b1; tick(4);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic frame(input logic [1:0] op, input logic [7:0] a);
        bit_out(1'b1);
        send_bits({30'd0, op}, 2);
        send_bits({24'd0, a}, 8);
    endtask

    task automatic cs_off();
        sck = 1'b0; sdi = 1'b0; cs = 1'b0; tick(6);
    endtask

    task automatic rd(input logic [7:0] a, input logic p, input int lead,
                      input string req, input logic [15:0] exp);
        logic [15:0] v;
        pre = p; cs = 1'b1; tick(4);
        repeat (lead) bit_out(1'b0);
        frame(2'b10, a);
        chk("R4 dummy bit", {30'd0, sdo_oe, sdo}, 32'd2);
        for (int i = 15; i >= 0; i--) begin
            bit_out(1'b0);
            v[i] = sdo;
        end
        chk(req, {16'd0, v}, {16'd0, exp});
        bit_out(1'b0);
        chk("R4 release", {31'd0, sdo_oe}, 32'd0);
        cs_off();
        pre = 1'b0;
    endtask

    // issue a command, reselect and look at status: busy shown iff accepted
    task automatic prog(input logic [1:0] op, input logic [7:0] a, input logic has_data,
                        input logic [15:0] d, input logic p, input logic go, input string req);
        pre = p; cs = 1'b1; tick(4);
        frame(op, a);
        if (has_data) send_bits({16'd0, d}, 16);
        cs_off();
        cs = 1'b1; tick(4);
        chk(req, {30'd0, sdo_oe, sdo}, go ? 32'd2 : 32'd0);
        tick(PROG_WAIT);
        cs_off();
        pre = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a;
        logic [15:0] d;
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        tick(6);
        rst = 1'b0;
        tick(4);
        chk("R1 reset hi-z", {31'd0, sdo_oe}, 32'd0);

        rd(8'd3, 1'b0, 5, "R2 leading clocks ignored", 16'hFFFF);

        prog(2'b01, 8'd10, 1'b1, 16'h1234, 1'b0, 1'b0, "R6 write while disabled");
        rd(8'd10, 1'b0, 0, "R6 word unchanged", 16'hFFFF);
        prog(2'b00, 8'hC0, 1'b0, 16'h0, 1'b0, 1'b0, "R6 enable no cycle");
        prog(2'b01, 8'd10, 1'b1, 16'h1234, 1'b0, 1'b1, "R3 write accepted");
        rd(8'd10, 1'b0, 0, "R3 readback", 16'h1234);
        prog(2'b11, 8'd10, 1'b0, 16'h0, 1'b0, 1'b1, "R7 erase accepted");
        rd(8'd10, 1'b0, 0, "R7 erased word", 16'hFFFF);

        pe = 1'b0;
        prog(2'b01, 8'd20, 1'b1, 16'h4321, 1'b0, 1'b0, "R13 write with PE low");
        pe = 1'b1;
        rd(8'd20, 1'b0, 0, "R13 word unchanged", 16'hFFFF);

        // R9: select held high through the cycle, no status
        cs = 1'b1; tick(4);
        frame(2'b01, 8'd30);
        send_bits(32'h0000AAAA, 16);
        tick(10);
        chk("R9 no status while held", {31'd0, sdo_oe}, 32'd0);
        tick(PROG_WAIT);
        chk("R9 no status after", {31'd0, sdo_oe}, 32'd0);
        cs_off();
        model[30] = 16'hAAAA;
        rd(8'd30, 1'b0, 0, "R9 held write stored", 16'hAAAA);

        // R5: abort a write partway
        cs = 1'b1; tick(4);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b0);
        cs_off();
        rd(8'd30, 1'b0, 0, "R5 aborted frame no effect", 16'hAAAA);

        // R8 and R9: frame during busy ignored, status busy then ready
        cs = 1'b1; tick(4);
        frame(2'b01, 8'd40);
        send_bits(32'h00005555, 16);
        cs_off();
        cs = 1'b1; tick(4);
        chk("R9 busy status", {30'd0, sdo_oe, sdo}, 32'd2);
        frame(2'b10, 8'd0);
        chk("R8 frame ignored, ready shown", {30'd0, sdo_oe, sdo}, 32'd3);
        cs_off();
        chk("R9 status released", {31'd0, sdo_oe}, 32'd0);
        model[40] = 16'h5555;
        rd(8'd40, 1'b0, 0, "R8 first write kept", 16'h5555);

        for (int n = 0; n < 14; n++) begin
            a = 8'($urandom_range(0, 255));
            d = 16'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                prog(2'b11, a, 1'b0, 16'h0, 1'b0, 1'b1, "R7 random erase");
                model[a] = 16'hFFFF;
            end else begin
                prog(2'b01, a, 1'b1, d, 1'b0, 1'b1, "R3 random write");
                model[a] = d;
            end
            rd(a, 1'b0, $urandom_range(0, 2), "R3 random readback", model[a]);
        end

        prog(2'b00, 8'h00, 1'b0, 16'h0, 1'b0, 1'b0, "R6 disable no cycle");
        prog(2'b01, 8'd50, 1'b1, 16'h0BAD, 1'b0, 1'b0, "R6 write after disable");
        rd(8'd50, 1'b0, 0, "R6 disabled word", model[50]);
        prog(2'b00, 8'hC0, 1'b0, 16'h0, 1'b0, 1'b0, "R6 re-enable");

        // protection
        rd(8'd0, 1'b1, 0, "R10 boundary reset value", 16'h0100);
        prog(2'b00, 8'hC0, 1'b0, 16'h0, 1'b1, 1'b0, "R11 arm");
        prog(2'b01, 8'h80, 1'b0, 16'h0, 1'b1, 1'b1, "R11 set boundary");
        rd(8'd0, 1'b1, 0, "R11 boundary readback", 16'h0080);
        prog(2'b01, 8'h90, 1'b1, 16'h7777, 1'b0, 1'b0, "R10 protected write");
        rd(8'h90, 1'b0, 0, "R10 protected word", model[8'h90]);
        prog(2'b01, 8'h7F, 1'b1, 16'h6666, 1'b0, 1'b1, "R10 write below boundary");
        model[8'h7F] = 16'h6666;
        rd(8'h7F, 1'b0, 0, "R10 below boundary stored", 16'h6666);
        prog(2'b01, 8'h20, 1'b0, 16'h0, 1'b1, 1'b0, "R11 set without arm");
        rd(8'd0, 1'b1, 0, "R11 boundary kept", 16'h0080);
        prog(2'b00, 8'h00, 1'b0, 16'h0, 1'b1, 1'b0, "R12 lock without arm");
        prog(2'b00, 8'hC0, 1'b0, 16'h0, 1'b1, 1'b0, "R11 arm");
        pe = 1'b0;
        prog(2'b11, 8'h00, 1'b0, 16'h0, 1'b1, 1'b0, "R13 clear with PE low");
        pe = 1'b1;
        prog(2'b00, 8'hC0, 1'b0, 16'h0, 1'b1, 1'b0, "R11 arm");
        prog(2'b11, 8'h00, 1'b0, 16'h0, 1'b1, 1'b1, "R12 clear works before lock");
        rd(8'd0, 1'b1, 0, "R11 cleared boundary", 16'h0100);
        prog(2'b00, 8'hC0, 1'b0, 16'h0, 1'b1, 1'b0, "R11 arm");
        prog(2'b01, 8'h80, 1'b0, 16'h0, 1'b1, 1'b1, "R11 set boundary again");
        prog(2'b00, 8'hC0, 1'b0, 16'h0, 1'b1, 1'b0, "R12 arm");
        prog(2'b00, 8'h00, 1'b0, 16'h0, 1'b1, 1'b1, "R12 lock accepted");
        prog(2'b00, 8'hC0, 1'b0, 16'h0, 1'b1, 1'b0, "R12 arm");
        prog(2'b11, 8'h00, 1'b0, 16'h0, 1'b1, 1'b0, "R12 clear after lock");
        rd(8'd0, 1'b1, 0, "R12 boundary frozen", 16'h0080);
        prog(2'b01, 8'hA0, 1'b1, 16'h1111, 1'b0, 1'b0, "R10 protected after lock");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule